// File: doc/BRIEF.md
# Shift and Rotate Unit with Flags

This block is a purely combinational shifter for an 8-bit or 16-bit operand. One select input picks among left shift, logical right shift, sign-preserving right shift, plain rotates in both directions, and rotates that pass through the carry flag. A separate width bit sets the operand size. The count is a 5-bit value, either the constant 1 or a register value. The block returns the shifted result and five condition flags: carry, overflow, sign, zero and parity.

The block also drives three write-enable outputs. These tell the surrounding datapath which flags the operation really updates, so the flag register can keep the other flags unchanged. Shift operations and rotate operations write different sets of flags. Overflow is meaningful only for a single-bit count. For any other count, overflow is driven to zero and reported as not written. A count of zero changes nothing.

Top module: `shift_rotate_unit`

## Requirements
- R1: The operation code `op_i` decodes as 0 = left shift, 1 = logical right shift, 2 = arithmetic right shift, 3 = rotate left, 4 = rotate right, 5 = rotate left through carry, 6 = rotate right through carry, 7 = left shift (an alias of code 0). A left shift fills with zeros, and `cf_o` is the last bit shifted out (0 when the count exceeds the width).
- R2: A logical right shift fills with zeros, and `cf_o` is the last bit shifted out. For example, 80h shifted right by 1 in byte mode gives 40h.
- R3: An arithmetic right shift refills with the original sign bit, so a negative operand stays negative for every count. A count at or above the width gives all sign bits, with `cf_o` equal to the sign.
- R4: Plain rotates use the count modulo the width. `cf_o` is the bit that wrapped around: the result LSB for a left rotate, the result MSB for a right rotate. For example, F0h rotated left by 1 gives E1h, and 3Fh rotated left by 4 gives F3h.
- R5: Through-carry rotates treat {carry, operand} as one ring of width+1 bits and use the count modulo width+1. For example, 88h with carry 0 rotated left once gives 10h with carry 1.
- R6: `wide_i` = 1 selects 16 bits. `wide_i` = 0 selects the low 8 bits. In byte mode the upper operand byte is ignored and `res_o[15:8]` is 0.
- R7: A count of 0 returns the operand in the active width, gives `cf_o` = `cf_i` and `of_o` = 0, and holds all write enables low.
- R8: For a nonzero count, `cf_we_o` = 1. `szp_we_o` = 1 only for shift codes (0, 1, 2, 7), never for rotates. `of_we_o` = 1 exactly when the count is 1.
- R9: For a count of 1, `of_o` is set by the operation:
  - left shift and both left rotates: result MSB XOR `cf_o`
  - both right rotates: XOR of the two top result bits
  - logical right shift: the original MSB
  - arithmetic right shift: 0

  For any other count, `of_o` = 0.
- R10: Whatever the operation, `sf_o` is the MSB of the active width, `zf_o` is 1 when the active-width result is zero, and `pf_o` is 1 when `res_o[7:0]` holds an even number of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 16 | Operand; only bits 7:0 are used in byte mode |
| cnt_i | input | 5 | Shift or rotate count |
| op_i | input | 3 | Operation code |
| wide_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| cf_i | input | 1 | Incoming carry flag |
| res_o | output | 16 | Result |
| cf_o | output | 1 | Carry flag out |
| of_o | output | 1 | Overflow flag out |
| sf_o | output | 1 | Sign flag out |
| zf_o | output | 1 | Zero flag out |
| pf_o | output | 1 | Parity flag out (even parity of the low byte) |
| cf_we_o | output | 1 | Carry flag is written |
| of_we_o | output | 1 | Overflow flag is written |
| szp_we_o | output | 1 | Sign, zero and parity flags are written |

## Verification
The assertions are immediate checks on the settled combinational outputs. They assume that every input is driven to a known 0/1 value and that all inputs stay stable while the outputs are sampled. The bench changes inputs only shortly after a clock edge and samples one edge later. The checks also assume that the upper operand byte may hold anything in byte mode. The stimulus deliberately places non-zero upper bytes there to show that they have no effect. Count values cover 0, 1, the width, multiples of the ring size and the 5-bit maximum, so every modulo and saturation path is reached.

// File: rtl/shift_rotate_pkg.sv
`timescale 1ns/1ps
package shift_rotate_pkg;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_ROL = 3'd3,
    OP_ROR = 3'd4,
    OP_RCL = 3'd5,
    OP_RCR = 3'd6,
    OP_SAL = 3'd7
  } shrot_op_t;

  // true for the operations that write sign, zero and parity
  function automatic logic op_is_shift(input shrot_op_t op);
    return (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR) || (op == OP_SAL);
  endfunction

  // true for operations whose single-bit overflow uses result MSB ^ carry
  function automatic logic op_is_leftward(input shrot_op_t op);
    return (op == OP_SHL) || (op == OP_SAL) || (op == OP_ROL) || (op == OP_RCL);
  endfunction

  // even parity of a byte: 1 when the number of ones is even
  function automatic logic even_parity8(input logic [7:0] b);
    return ~^b;
  endfunction

endpackage

// File: rtl/shrot_lane.sv
`timescale 1ns/1ps
module shrot_lane
  import shift_rotate_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = 5
) (
  input  logic [W-1:0]  data_i,
  input  logic [CW-1:0] cnt_i,
  input  shrot_op_t     op_i,
  input  logic          cf_i,
  output logic [W-1:0]  res_o,
  output logic          cf_o,
  output logic          of1_o
);

  localparam int SPAN = 1 << CW;   // largest count plus one
  localparam int PW   = W + SPAN;  // padded shift width
  localparam int RW   = W + 1;     // through-carry ring width

  // left shift: the last bit out lands at position W
  function automatic logic [W:0] f_shl(input logic [W-1:0] d, input logic [CW-1:0] n);
    logic [PW-1:0] t;
    t = {{SPAN{1'b0}}, d} << n;
    return t[W:0];
  endfunction

  // right shift (logical or arithmetic): the last bit out lands at SPAN-1
  function automatic logic [W:0] f_shr(input logic [W-1:0] d, input logic [CW-1:0] n,
                                      input logic arith);
    logic [PW-1:0] t;
    if (arith) t = $signed({d, {SPAN{1'b0}}}) >>> n;
    else       t = {d, {SPAN{1'b0}}} >> n;
    return {t[PW-1:SPAN], t[SPAN-1]};
  endfunction

  function automatic logic [W-1:0] f_rot(input logic [W-1:0] d, input logic [CW-1:0] k,
                                         input logic left);
    logic [2*W-1:0] t;
    if (left) begin
      t = {d, d} << k;
      return t[2*W-1:W];
    end
    t = {d, d} >> k;
    return t[W-1:0];
  endfunction

  function automatic logic [RW-1:0] f_ring(input logic [RW-1:0] r, input logic [CW-1:0] k,
                                           input logic left);
    logic [2*RW-1:0] t;
    if (left) begin
      t = {r, r} << k;
      return t[2*RW-1:RW];
    end
    t = {r, r} >> k;
    return t[RW-1:0];
  endfunction

  logic [CW-1:0] k_rot;
  logic [CW-1:0] k_ring;
  logic [W:0]    shl_v;
  logic [W:0]    shr_v;
  logic [W:0]    sar_v;
  logic [W-1:0]  rol_v;
  logic [W-1:0]  ror_v;
  logic [RW-1:0] rcl_v;
  logic [RW-1:0] rcr_v;

  assign k_rot  = CW'(int'(cnt_i) % W);
  assign k_ring = CW'(int'(cnt_i) % RW);
  assign shl_v  = f_shl(data_i, cnt_i);
  assign shr_v  = f_shr(data_i, cnt_i, 1'b0);
  assign sar_v  = f_shr(data_i, cnt_i, 1'b1);
  assign rol_v  = f_rot(data_i, k_rot, 1'b1);
  assign ror_v  = f_rot(data_i, k_rot, 1'b0);
  assign rcl_v  = f_ring({cf_i, data_i}, k_ring, 1'b1);
  assign rcr_v  = f_ring({cf_i, data_i}, k_ring, 1'b0);

  always_comb begin
    unique case (op_i)
      OP_SHL, OP_SAL: begin res_o = shl_v[W-1:0]; cf_o = shl_v[W]; end
      OP_SHR:         begin res_o = shr_v[W:1];   cf_o = shr_v[0]; end
      OP_SAR:         begin res_o = sar_v[W:1];   cf_o = sar_v[0]; end
      OP_ROL:         begin res_o = rol_v;        cf_o = rol_v[0]; end
      OP_ROR:         begin res_o = ror_v;        cf_o = ror_v[W-1]; end
      OP_RCL:         begin res_o = rcl_v[W-1:0]; cf_o = rcl_v[W]; end
      default:        begin res_o = rcr_v[W-1:0]; cf_o = rcr_v[W]; end
    endcase
  end

  // overflow as it would be for a single-bit count
  always_comb begin
    if (op_is_leftward(op_i))                      of1_o = res_o[W-1] ^ cf_o;
    else if (op_i == OP_ROR || op_i == OP_RCR)     of1_o = res_o[W-1] ^ res_o[W-2];
    else if (op_i == OP_SHR)                       of1_o = data_i[W-1];
    else                                           of1_o = 1'b0;
  end

endmodule

// File: rtl/shrot_status.sv
`timescale 1ns/1ps
module shrot_status
  import shift_rotate_pkg::*;
#(
  parameter int DW = 16,
  parameter int HW = 8
) (
  input  logic [DW-1:0] res_i,
  input  logic          wide_i,
  input  shrot_op_t     op_i,
  input  logic          cnt_zero_i,
  input  logic          cnt_one_i,
  input  logic          lane_cf_i,
  input  logic          lane_of1_i,
  input  logic          cf_i,
  output logic          cf_o,
  output logic          of_o,
  output logic          sf_o,
  output logic          zf_o,
  output logic          pf_o,
  output logic          cf_we_o,
  output logic          of_we_o,
  output logic          szp_we_o
);

  assign sf_o = wide_i ? res_i[DW-1] : res_i[HW-1];
  assign zf_o = wide_i ? (res_i == '0) : (res_i[HW-1:0] == '0);
  assign pf_o = even_parity8(res_i[7:0]);

  assign cf_o = cnt_zero_i ? cf_i : lane_cf_i;
  assign of_o = cnt_one_i & lane_of1_i;

  assign cf_we_o  = !cnt_zero_i;
  assign of_we_o  = cnt_one_i;
  assign szp_we_o = !cnt_zero_i && op_is_shift(op_i);

endmodule

// File: rtl/shift_rotate_unit.sv
`timescale 1ns/1ps
module shift_rotate_unit
  import shift_rotate_pkg::*;
#(
  parameter int DW = 16,
  parameter int HW = 8,
  parameter int CW = 5
) (
  input  logic [DW-1:0] opnd_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [2:0]    op_i,
  input  logic          wide_i,
  input  logic          cf_i,
  output logic [DW-1:0] res_o,
  output logic          cf_o,
  output logic          of_o,
  output logic          sf_o,
  output logic          zf_o,
  output logic          pf_o,
  output logic          cf_we_o,
  output logic          of_we_o,
  output logic          szp_we_o
);

  localparam int NLANE = 2;   // lane 0 byte, lane 1 word

  shrot_op_t op;
  logic      cnt_zero;
  logic      cnt_one;

  logic [NLANE-1:0][DW-1:0] lane_res;
  logic [NLANE-1:0]         lane_cf;
  logic [NLANE-1:0]         lane_of1;
  logic [DW-1:0]            sel_res;

  assign op       = shrot_op_t'(op_i);
  assign cnt_zero = (cnt_i == '0);
  assign cnt_one  = (cnt_i == CW'(1));

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = (g == 0) ? HW : DW;
    logic [LW-1:0] r;
    shrot_lane #(.W(LW), .CW(CW)) u_lane (
      .data_i (opnd_i[LW-1:0]),
      .cnt_i  (cnt_i),
      .op_i   (op),
      .cf_i   (cf_i),
      .res_o  (r),
      .cf_o   (lane_cf[g]),
      .of1_o  (lane_of1[g])
    );
    assign lane_res[g] = DW'(r);
  end

  // a zero count passes the operand, trimmed to the active width
  always_comb begin
    if (cnt_zero) sel_res = wide_i ? opnd_i : DW'(opnd_i[HW-1:0]);
    else          sel_res = lane_res[wide_i];
  end
  assign res_o = sel_res;

  shrot_status #(.DW(DW), .HW(HW)) u_status (
    .res_i      (sel_res),
    .wide_i     (wide_i),
    .op_i       (op),
    .cnt_zero_i (cnt_zero),
    .cnt_one_i  (cnt_one),
    .lane_cf_i  (lane_cf[wide_i]),
    .lane_of1_i (lane_of1[wide_i]),
    .cf_i       (cf_i),
    .cf_o       (cf_o),
    .of_o       (of_o),
    .sf_o       (sf_o),
    .zf_o       (zf_o),
    .pf_o       (pf_o),
    .cf_we_o    (cf_we_o),
    .of_we_o    (of_we_o),
    .szp_we_o   (szp_we_o)
  );

endmodule

// File: rtl/shift_rotate_unit_chk.sv
`timescale 1ns/1ps
module shift_rotate_unit_chk #(
  parameter int DW = 16,
  parameter int HW = 8,
  parameter int CW = 5
) (
  input logic [DW-1:0] opnd_i,
  input logic [CW-1:0] cnt_i,
  input logic [2:0]    op_i,
  input logic          wide_i,
  input logic          cf_i,
  input logic [DW-1:0] res_o,
  input logic          cf_o,
  input logic          of_o,
  input logic          sf_o,
  input logic          zf_o,
  input logic          pf_o,
  input logic          cf_we_o,
  input logic          of_we_o,
  input logic          szp_we_o
);

  logic is_rot;
  logic [DW-1:0] act_res;
  assign is_rot  = (op_i >= 3'd3) && (op_i <= 3'd6);
  assign act_res = wide_i ? res_o : DW'(res_o[HW-1:0]);

  always_comb begin
    // R7
    hold_on_zero_chk: assert (cnt_i != '0 ||
      (act_res == (wide_i ? opnd_i : DW'(opnd_i[HW-1:0])) && cf_o == cf_i &&
       !of_o && !cf_we_o && !of_we_o && !szp_we_o));
    // R8
    rot_keeps_szp_chk: assert (!is_rot || !szp_we_o);
    // R8
    carry_written_chk: assert (cnt_i == '0 || cf_we_o);
    // R9
    of_single_chk: assert (cnt_i == CW'(1) || (!of_o && !of_we_o));
    // R6
    byte_upper_clear_chk: assert (wide_i || res_o[DW-1:HW] == '0);
    // R4
    rot_cf_wrap_chk: assert (cnt_i == '0 ||
      !(op_i == 3'd3 || op_i == 3'd4) ||
      cf_o == ((op_i == 3'd3) ? res_o[0] : (wide_i ? res_o[DW-1] : res_o[HW-1])));
    // R10
    zero_sign_chk: assert (zf_o == (act_res == '0) &&
      sf_o == (wide_i ? res_o[DW-1] : res_o[HW-1]));
  end

endmodule

bind shift_rotate_unit shift_rotate_unit_chk #(.DW(DW), .HW(HW), .CW(CW)) u_chk (.*);

// File: tb/shift_rotate_unit_test.sv
`timescale 1ns/1ps
module shift_rotate_unit_test;

  typedef struct packed {
    logic [2:0]  op;
    logic        wide;
    logic [4:0]  cnt;
    logic        cf;
    logic [15:0] opnd;
    logic [15:0] res;
    logic        ecf;
    logic        eof;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b0, 5'd1,  1'b0, 16'h0005, 16'h000A, 1'b0, 1'b0, 4'd1},  // R1
    '{3'd0, 1'b0, 5'd2,  1'b0, 16'h0005, 16'h0014, 1'b0, 1'b0, 4'd1},  // R1
    '{3'd0, 1'b0, 5'd1,  1'b0, 16'h0081, 16'h0002, 1'b1, 1'b1, 4'd9},  // R9
    '{3'd0, 1'b1, 5'd1,  1'b0, 16'h8001, 16'h0002, 1'b1, 1'b1, 4'd9},  // R9
    '{3'd7, 1'b0, 5'd1,  1'b0, 16'h0005, 16'h000A, 1'b0, 1'b0, 4'd1},  // R1 alias
    '{3'd1, 1'b0, 5'd1,  1'b0, 16'h0080, 16'h0040, 1'b0, 1'b1, 4'd2},  // R2
    '{3'd1, 1'b0, 5'd2,  1'b0, 16'h0080, 16'h0020, 1'b0, 1'b0, 4'd2},  // R2
    '{3'd1, 1'b0, 5'd8,  1'b0, 16'h0081, 16'h0000, 1'b1, 1'b0, 4'd2},  // R2
    '{3'd2, 1'b0, 5'd1,  1'b0, 16'h00B0, 16'h00D8, 1'b0, 1'b0, 4'd3},  // R3
    '{3'd2, 1'b0, 5'd2,  1'b0, 16'h00B0, 16'h00EC, 1'b0, 1'b0, 4'd3},  // R3
    '{3'd2, 1'b0, 5'd12, 1'b0, 16'h0080, 16'h00FF, 1'b1, 1'b0, 4'd3},  // R3
    '{3'd2, 1'b1, 5'd20, 1'b0, 16'h8000, 16'hFFFF, 1'b1, 1'b0, 4'd3},  // R3
    '{3'd3, 1'b0, 5'd1,  1'b0, 16'h00F0, 16'h00E1, 1'b1, 1'b0, 4'd4},  // R4
    '{3'd3, 1'b0, 5'd4,  1'b0, 16'h003F, 16'h00F3, 1'b1, 1'b0, 4'd4},  // R4
    '{3'd4, 1'b0, 5'd1,  1'b0, 16'h00F0, 16'h0078, 1'b0, 1'b1, 4'd4},  // R4
    '{3'd4, 1'b0, 5'd4,  1'b0, 16'h003F, 16'h00F3, 1'b1, 1'b0, 4'd4},  // R4
    '{3'd3, 1'b0, 5'd8,  1'b0, 16'h0081, 16'h0081, 1'b1, 1'b0, 4'd4},  // R4
    '{3'd3, 1'b1, 5'd4,  1'b0, 16'h8001, 16'h0018, 1'b0, 1'b0, 4'd4},  // R4
    '{3'd5, 1'b0, 5'd1,  1'b0, 16'h0088, 16'h0010, 1'b1, 1'b1, 4'd5},  // R5
    '{3'd5, 1'b0, 5'd1,  1'b1, 16'h0010, 16'h0021, 1'b0, 1'b0, 4'd5},  // R5
    '{3'd6, 1'b0, 5'd1,  1'b1, 16'h0010, 16'h0088, 1'b0, 1'b1, 4'd5},  // R5
    '{3'd5, 1'b0, 5'd9,  1'b1, 16'h0055, 16'h0055, 1'b1, 1'b0, 4'd5},  // R5
    '{3'd6, 1'b1, 5'd17, 1'b0, 16'h0001, 16'h0001, 1'b0, 1'b0, 4'd5},  // R5
    '{3'd6, 1'b1, 5'd2,  1'b0, 16'h0001, 16'h8000, 1'b0, 1'b0, 4'd5},  // R5
    '{3'd0, 1'b0, 5'd1,  1'b0, 16'hAB05, 16'h000A, 1'b0, 1'b0, 4'd6},  // R6
    '{3'd0, 1'b0, 5'd0,  1'b1, 16'h1234, 16'h0034, 1'b1, 1'b0, 4'd7},  // R7
    '{3'd4, 1'b1, 5'd0,  1'b0, 16'h1234, 16'h1234, 1'b0, 1'b0, 4'd7},  // R7
    '{3'd0, 1'b1, 5'd3,  1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd10}  // R10
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] opnd;
  logic [4:0]  cnt;
  logic [2:0]  op;
  logic        wide;
  logic        cfi;
  logic [15:0] res;
  logic        cfo, ofo, sfo, zfo, pfo, cfwe, ofwe, szpwe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shift_rotate_unit uut (
    .opnd_i(opnd), .cnt_i(cnt), .op_i(op), .wide_i(wide), .cf_i(cfi),
    .res_o(res), .cf_o(cfo), .of_o(ofo), .sf_o(sfo), .zf_o(zfo), .pf_o(pfo),
    .cf_we_o(cfwe), .of_we_o(ofwe), .szp_we_o(szpwe)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic w, input logic [4:0] c,
                       input logic f, input logic [15:0] d);
    op = o; wide = w; cnt = c; cfi = f; opnd = d;
    @(posedge clk);
    #1;
  endtask

  // flag and enable model written from the requirements
  task automatic chk_side(input string req, input logic [2:0] o, input logic w,
                          input logic [4:0] c, input logic [15:0] r);
    logic shift_op;
    shift_op = (o == 3'd0) || (o == 3'd1) || (o == 3'd2) || (o == 3'd7);
    chk("R10", {req, " sf"}, 16'(sfo), 16'(w ? r[15] : r[7]));
    chk("R10", {req, " zf"}, 16'(zfo), 16'(w ? (r == 16'h0) : (r[7:0] == 8'h0)));
    chk("R10", {req, " pf"}, 16'(pfo), 16'(~^r[7:0]));
    chk("R8",  {req, " cf_we"}, 16'(cfwe), 16'(c != 5'd0));
    chk("R8",  {req, " of_we"}, 16'(ofwe), 16'(c == 5'd1));
    chk("R8",  {req, " szp_we"}, 16'(szpwe), 16'((c != 5'd0) && shift_op));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    op = 3'd0; wide = 1'b0; cnt = 5'd0; cfi = 1'b0; opnd = 16'h0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // reset state: idle inputs, count 0 (R7)
    chk("R7", "idle res", res, 16'h0);
    chk("R7", "idle cf", 16'(cfo), 16'h0);
    chk("R7", "idle we", 16'({cfwe, ofwe, szpwe}), 16'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i].rq);
      drive(VEC[i].op, VEC[i].wide, VEC[i].cnt, VEC[i].cf, VEC[i].opnd);
      chk(tag, $sformatf("vec%0d res", i), res, VEC[i].res);
      chk(tag, $sformatf("vec%0d cf", i), 16'(cfo), 16'(VEC[i].ecf));
      chk("R9", $sformatf("vec%0d of", i), 16'(ofo), 16'(VEC[i].eof));
      chk_side($sformatf("vec%0d", i), VEC[i].op, VEC[i].wide, VEC[i].cnt, VEC[i].res);
    end

    // R3: negative word stays negative for every count
    for (int c = 1; c < 32; c++) begin
      drive(3'd2, 1'b1, 5'(c), 1'b0, 16'h8123);
      chk("R3", $sformatf("sar sign cnt%0d", c), 16'({sfo, res[15]}), 16'h3);
    end

    // R5: nine single steps of a byte through-carry rotate restore the ring
    begin
      logic [15:0] d;
      logic        f;
      d = 16'h005A; f = 1'b0;
      for (int s = 0; s < 9; s++) begin
        drive(3'd5, 1'b0, 5'd1, f, d);
        d = res; f = cfo;
      end
      chk("R5", "rcl ring restore", d, 16'h005A);
      chk("R5", "rcl ring carry", 16'(f), 16'h0);
    end

    // R6: upper byte ignored in byte mode for a rotate
    drive(3'd4, 1'b0, 5'd3, 1'b0, 16'hFF01);
    chk("R6", "byte ror upper ignored", res, 16'h0020);

    // R9: count other than 1 leaves overflow clear
    drive(3'd0, 1'b0, 5'd31, 1'b1, 16'h00FF);
    chk("R9", "of at cnt31", 16'({ofo, ofwe}), 16'h0);
    chk("R1", "shl beyond width", 16'({res, cfo}), 16'h0);

    finish_run();
  end

endmodule